// File: doc/BRIEF.md
# Bit-Serial Four-Tap Dot-Product Engine with Error Output

This block forms the inner product of four signed weights with the four most recent signed input samples, and it uses no multiplier. It keeps a table of every subset sum of the sample window. The window is held in registers, and the table is refilled whenever a new sample is accepted. The weights are then walked one bit position at a time, least significant position first. At each position, the four weight bits at that position form a 4-bit address that selects one table entry. The selected entry is shifted to the weight of that position and added into a carry-save accumulator.

When the last position has been added, one carry-propagate addition merges the sum and carry words into the filter output. The same clock edge also registers the difference between the desired sample and that output, as the error value of an adaptive loop. An outer controller strobes `start` once per sample, with the new sample, the current weights and the desired value. It then waits for the one-cycle `done` pulse. Step-size scaling and the weight update belong to the surrounding logic and are not part of this block.

Top module: `da_inner_product`

## Requirements
- R1: After reset, `y_out`, `e_out` and `done` are zero, and all sample history is zero. The first computation therefore sees zero for the three older taps.
- R2: Each accepted `start` shifts `x_in` into the sample window as the newest sample x[n]. The older samples move back one place to x[n-1], x[n-2] and x[n-3], and the oldest one is dropped. The output is y = w0·x[n] + w1·x[n-1] + w2·x[n-2] + w3·x[n-3], where `w0_in`..`w3_in` are the weights presented with that `start`.
- R3: Samples and weights are two's complement over their full range, including the most negative code. y is exact in the AW = XW+WW+2 bit two's complement `y_out`.
- R4: `e_out` equals `d_in` − y, with `d_in` taken as an AW-bit two's complement value. The result is exact in AW+1 bits for all input values.
- R5: `done` is high for exactly one clock. It rises at the (WW+1)-th rising edge after the edge that accepted `start`. `y_out` and `e_out` change only at that edge and hold their values until the next `done`.
- R6: A `start` that arrives while a computation is in progress is ignored. Its sample does not enter the window, and its weights and desired value have no effect. Changing `w*_in` or `d_in` after the accepting edge also has no effect.
- R7: Table entry k holds the sum of the samples x[n-j] for which bit j of k is set. Entry 0 is a constant zero. When all four weights are zero, y is 0 and e equals `d_in`.
- R8: The bit slice at the most significant weight position is subtracted from the accumulator and the lower slices are added. The single final addition supplies the +1 that completes the two's complement negation.

Top module parameters: XW sample width (default 8) and WW weight width (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept a new sample and begin a computation (taken only when idle) |
| x_in | input | XW | New input sample, two's complement |
| w0_in | input | WW | Weight for x[n] |
| w1_in | input | WW | Weight for x[n-1] |
| w2_in | input | WW | Weight for x[n-2] |
| w3_in | input | WW | Weight for x[n-3] |
| d_in | input | XW+WW+2 | Desired sample, two's complement |
| y_out | output | XW+WW+2 | Inner product result |
| e_out | output | XW+WW+3 | Error d − y |
| done | output | 1 | One-cycle pulse when `y_out` and `e_out` are updated |

## Verification
The assertions check several properties on every cycle:
- `done` lasts exactly one cycle, and it follows the accepting edge after exactly WW+1 cycles.
- A `start` during a computation leaves the latched desired value untouched.
- A refill moves each table entry into its shifted-window position, and a zero slice selects a zero addend.
- A cleared accumulator starts from zero in both words.

Only the bench scenarios can show that the numeric result is right. That takes a reference dot product over a four-deep window, full-range corner codes, the error at the extremes of `d_in`, and the rejection of a mid-run `start` as seen in later results.

// File: rtl/da_ip_pkg.sv
package da_ip_pkg;
   localparam int unsigned TAPS  = 4;
   localparam int unsigned SLOTS = 1 << TAPS;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_FIN  = 2'd2
   } da_state_e;
endpackage

// File: rtl/da_sum_table.sv
// Subset-sum table over a sliding four-sample window.
// Bit j of the slot index selects x[n-j]. On refill, odd slots take the new
// sample plus the old slot k>>1 (seven adders, slot 1 needs none); even slots
// copy old slot k>>1.
module da_sum_table
   import da_ip_pkg::*;
#(
   parameter int unsigned XW = 8,
   parameter int unsigned TW = XW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [XW-1:0]        x_in,
   output logic [TW-1:0]        slot_o [SLOTS]
);
   if (TW < XW + 2) begin : g_bad_tw
      $error("da_sum_table: TW must hold a four-sample sum");
   end

   logic [TW-1:0] x_ext;
   assign x_ext = {{(TW-XW){x_in[XW-1]}}, x_in};

   assign slot_o[0] = '0;

   for (genvar k = 1; k < SLOTS; k++) begin : g_slot
      logic [TW-1:0] q;
      logic [TW-1:0] nxt;
      if (k == 1) begin : g_new
         assign nxt = x_ext;
      end else if ((k % 2) == 1) begin : g_add
         assign nxt = x_ext + slot_o[k >> 1];
      end else begin : g_move
         assign nxt = slot_o[k >> 1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= nxt;
      end
      assign slot_o[k] = q;
   end

   // R2: newest sample lands in slot 1, and the previous newest moves to slot 2
   assert_slot_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (slot_o[1] == $past(x_ext)) && (slot_o[2] == $past(slot_o[1])))
      else $error("slot refill mismatch");
   // R6: without a refill the window is frozen
   assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(slot_o[15]) && $stable(slot_o[1]))
      else $error("table changed without load");
endmodule

// File: rtl/da_slice_mux.sv
// 16:1 selection of a table entry by one bit slice of the four weights.
module da_slice_mux
   import da_ip_pkg::*;
#(
   parameter int unsigned TW = 10
) (
   input  logic [TW-1:0]   slot_i [SLOTS],
   input  logic [TAPS-1:0] sel_i,
   output logic [TW-1:0]   pick_o
);
   always_comb pick_o = slot_i[sel_i];
endmodule

// File: rtl/da_csa_acc.sv
// Carry-save accumulator. The addend is sign-extended, weighted by its bit
// position and inverted on the last (sign) slice.
module da_csa_acc #(
   parameter int unsigned TW = 10,
   parameter int unsigned AW = 18,
   parameter int unsigned WW = 8,
   localparam int unsigned CW = $clog2(WW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic          last,
   input  logic [CW-1:0] shamt_i,
   input  logic [TW-1:0] pick_i,
   output logic [AW-1:0] sum_o,
   output logic [AW-1:0] carry_o
);
   if (AW <= TW) begin : g_bad_aw
      $error("da_csa_acc: AW must exceed TW");
   end

   logic [AW-1:0] add_ext, addend, s_nxt, c_nxt;

   always_comb begin
      add_ext = {{(AW-TW){pick_i[TW-1]}}, pick_i} << shamt_i;
      addend  = last ? ~add_ext : add_ext;
      s_nxt   = sum_o ^ carry_o ^ addend;
      c_nxt   = ((sum_o & carry_o) | (sum_o & addend) | (carry_o & addend)) << 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o   <= '0;
         carry_o <= '0;
      end else if (clr) begin
         sum_o   <= '0;
         carry_o <= '0;
      end else if (step) begin
         sum_o   <= s_nxt;
         carry_o <= c_nxt;
      end
   end

   // R8: each computation starts from an empty accumulator
   assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum_o == '0) && (carry_o == '0))
      else $error("accumulator not cleared");
   // R5: the accumulator only moves on a step
   assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(sum_o) && $stable(carry_o))
      else $error("accumulator moved while idle");
endmodule

// File: rtl/da_inner_product.sv
module da_inner_product
   import da_ip_pkg::*;
#(
   parameter int unsigned XW = 8,
   parameter int unsigned WW = 8,
   localparam int unsigned AW = XW + WW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [XW-1:0] x_in,
   input  logic [WW-1:0] w0_in,
   input  logic [WW-1:0] w1_in,
   input  logic [WW-1:0] w2_in,
   input  logic [WW-1:0] w3_in,
   input  logic [AW-1:0] d_in,
   output logic [AW-1:0] y_out,
   output logic [AW:0]   e_out,
   output logic          done
);
   localparam int unsigned TW = XW + 2;
   localparam int unsigned CW = $clog2(WW);

   if (WW < 2 || XW < 2) begin : g_bad_width
      $error("da_inner_product: XW and WW must be at least 2");
   end

   da_state_e     state;
   logic [CW-1:0] bit_idx;
   logic [WW-1:0] wsh [TAPS];
   logic [AW-1:0] d_q;
   logic [TAPS-1:0] slice;
   logic [TW-1:0] slot [SLOTS];
   logic [TW-1:0] pick;
   logic [AW-1:0] acc_s, acc_c, y_sum;
   logic          load, step, last;

   assign load = (state == ST_IDLE) && start;
   assign step = (state == ST_ACC);
   assign last = step && (bit_idx == CW'(WW - 1));

   for (genvar j = 0; j < TAPS; j++) begin : g_slice
      assign slice[j] = wsh[j][0];
   end

   da_sum_table #(.XW(XW), .TW(TW)) u_table (
      .clk(clk), .rst_n(rst_n), .load(load), .x_in(x_in), .slot_o(slot)
   );

   da_slice_mux #(.TW(TW)) u_mux (
      .slot_i(slot), .sel_i(slice), .pick_o(pick)
   );

   da_csa_acc #(.TW(TW), .AW(AW), .WW(WW)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(load), .step(step), .last(last),
      .shamt_i(bit_idx), .pick_i(pick), .sum_o(acc_s), .carry_o(acc_c)
   );

   assign y_sum = acc_s + acc_c + AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
         for (int j = 0; j < int'(TAPS); j++) wsh[j] <= '0;
         d_q     <= '0;
         y_out   <= '0;
         e_out   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               wsh[0]  <= w0_in;
               wsh[1]  <= w1_in;
               wsh[2]  <= w2_in;
               wsh[3]  <= w3_in;
               d_q     <= d_in;
               bit_idx <= '0;
               state   <= ST_ACC;
            end
            ST_ACC: begin
               for (int j = 0; j < int'(TAPS); j++) wsh[j] <= wsh[j] >> 1;
               bit_idx <= bit_idx + CW'(1);
               if (last) state <= ST_FIN;
            end
            ST_FIN: begin
               y_out <= y_sum;
               e_out <= {d_q[AW-1], d_q} - {y_sum[AW-1], y_sum};
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // cycle counter for the latency check
   logic [15:0] chk_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                chk_cyc <= '0;
      else if (load)             chk_cyc <= '0;
      else if (chk_cyc != '1)    chk_cyc <= chk_cyc + 16'd1;
   end

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");
   assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(chk_cyc) == WW + 1))
      else $error("done at wrong latency");
   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> $stable(d_q))
      else $error("start accepted while busy");
   assert_zero_slice_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && slice == '0) |-> (pick == '0))
      else $error("zero slice gave nonzero addend");
endmodule

// File: tb/da_inner_product_bench.sv
module da_inner_product_bench;
   localparam int XW = 8;
   localparam int WW = 8;
   localparam int AW = XW + WW + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [XW-1:0] x_in = '0;
   logic [WW-1:0] w0_in = '0, w1_in = '0, w2_in = '0, w3_in = '0;
   logic [AW-1:0] d_in = '0;
   logic signed [AW-1:0] y_out;
   logic signed [AW:0]   e_out;
   logic done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   longint hist [4];

   always #2 clk = ~clk;

   da_inner_product #(.XW(XW), .WW(WW)) u_da_inner_product (
      .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
      .w0_in(w0_in), .w1_in(w1_in), .w2_in(w2_in), .w3_in(w3_in),
      .d_in(d_in), .y_out(y_out), .e_out(e_out), .done(done)
   );

   task automatic check(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sx(longint v, int w);
      longint m = longint'(1) << w;
      v = v & (m - 1);
      return (v >= (m >> 1)) ? v - m : v;
   endfunction

   // one computation; when busy_poke is set a second start is driven mid-run
   task automatic run_one(longint x, longint w0, longint w1, longint w2,
                          longint w3, longint d, bit busy_poke);
      longint ey, ee;
      @(negedge clk);
      start = 1'b1;
      x_in  = XW'(x);
      w0_in = WW'(w0); w1_in = WW'(w1); w2_in = WW'(w2); w3_in = WW'(w3);
      d_in  = AW'(d);
      for (int j = 3; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = sx(x, XW);
      ey = sx(w0, WW) * hist[0] + sx(w1, WW) * hist[1]
         + sx(w2, WW) * hist[2] + sx(w3, WW) * hist[3];
      ee = sx(d, AW) - ey;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= WW + 2; k++) begin
         if (k > 1) @(negedge clk);
         if (busy_poke && k == 3) begin
            start = 1'b1;          // R6: must be ignored
            x_in  = XW'(x + 55);
            w0_in = ~w0_in; w3_in = ~w3_in;
            d_in  = ~d_in;
         end else if (busy_poke && k == 4) begin
            start = 1'b0;
         end
         if (k < WW + 2) check("R5 done low during run", longint'(done), 0);
      end
      check("R5 done pulse", longint'(done), 1);
      check("R2/R3 y", longint'(y_out), ey);
      check("R4 e", longint'(e_out), ee);
      @(negedge clk);
      check("R5 done single cycle", longint'(done), 0);
      check("R5 y held", longint'(y_out), ey);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int j = 0; j < 4; j++) hist[j] = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset y", longint'(y_out), 0);
      check("R1 reset e", longint'(e_out), 0);
      check("R1 reset done", longint'(done), 0);

      // R1: empty history, only the newest tap contributes
      run_one(37, 3, -5, 7, -9, 0, 1'b0);
      // R6: mid-run start with altered inputs, the next result uses the true window
      run_one(-20, 11, 13, -17, 19, 1000, 1'b1);
      run_one(5, 1, 1, 1, 1, -7, 1'b0);
      // R7: zero weights give y=0 and e=d
      run_one(99, 0, 0, 0, 0, 12345, 1'b0);
      // R3/R4: full-range corners
      repeat (4) run_one(-128, -128, -128, -128, -128, -131072, 1'b0);
      repeat (4) run_one(127, -128, -128, -128, -128, 131071, 1'b0);
      repeat (4) run_one(-128, 127, 127, 127, 127, 131071, 1'b0);
      // R8: only the sign slice set
      run_one(1, -128, 0, 0, 0, 0, 1'b0);
      run_one(-1, -1, -1, -1, -1, -1, 1'b0);

      // R2: constrained random mix
      for (int i = 0; i < 200; i++) begin
         longint rx, r0, r1, r2, r3, rd;
         rx = sx(longint'($urandom), XW);
         r0 = sx(longint'($urandom), WW);
         r1 = sx(longint'($urandom), WW);
         r2 = sx(longint'($urandom), WW);
         r3 = sx(longint'($urandom), WW);
         rd = sx(longint'($urandom), AW);
         run_one(rx, r0, r1, r2, r3, rd, (i % 7) == 3);
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule